// File: doc/BRIEF.md
# Single-Slope ADC Count Capture and Readout

This block is the digital back end of a shared single-slope (Wilkinson) converter. A start pulse raises the ramp-enable for the analog ramp. While the ramp runs, one Gray-code counter advances once per clock. Every channel has a comparator, and each channel keeps the counter value from the first clock in which its comparator reads high. Because successive Gray codes differ in a single bit, a value caught on a transition is off by at most one code.

When the ramp window closes, the block reads the stored codes out on a shared bus in ascending channel order, one per clock. Each code is converted from Gray back to binary and marked with a valid strobe and its channel number. A one-cycle done pulse ends the sequence. A channel whose comparator never switched reports the full-scale value. Start requests that arrive before done are dropped.

Top module: `ramp_adc_backend`

## Requirements
- R1: After synchronous reset, ramp_en_o, rd_valid_o and done_o are low and rd_chan_o and rd_code_o are zero.
- R2: When idle, a high start_i at a clock edge raises ramp_en_o from that edge. It stays high for exactly 2^NBITS clocks (256 by default), and cycle k of that window (k = 0..255) carries count k.
- R3: The internal counter steps through Gray codes g = b XOR (b >> 1) of the binary count b. The code a channel reports is the Gray-to-binary value of the count in the first ramp cycle where that channel's cmp_i bit is sampled high.
- R4: Only the first crossing counts. If a comparator later drops low and rises again in the same ramp, the stored value is unchanged.
- R5: A channel whose comparator is never sampled high during the ramp reports 255 (all ones) as an overflow code.
- R6: In the clock after the ramp window, readout begins. It lasts NCH (32) consecutive cycles with rd_valid_o high, rd_chan_o = 0, 1, ..., NCH-1 in that order, and rd_code_o holding that channel's binary code.
- R7: done_o is high for exactly one cycle, directly after the cycle for channel NCH-1. The block is then idle, with all outputs low, until the next start.
- R8: start_i is ignored during the ramp, during readout and in the done cycle. The ramp length, the codes and the readout are unaffected, and no new ramp follows done unless start_i is high again after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, accepted only when idle |
| cmp_i | input | NCH (32) | Comparator output for each channel, high once the ramp has passed the input |
| ramp_en_o | output | 1 | Enables the analog ramp during the count window |
| rd_valid_o | output | 1 | A readout word is present |
| rd_chan_o | output | log2(NCH) (5) | Channel number of the readout word |
| rd_code_o | output | NBITS (8) | Converted binary code |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
On every cycle, the assertions check the sequencing. The ramp window has the right length, the phases never overlap, readout starts at channel 0 and counts up by one per cycle, done follows the last channel, and a ramp only begins from an accepted start. Only the bench scenarios can show that the codes are correct. They drive thresholds per channel, including crossings at count 0, at 255 and never, and comparators that glitch after they cross. They also send start pulses in the middle of a conversion. The values read out are compared with each channel's crossing count.

// File: rtl/adc_pkg.sv
package adc_pkg;

    localparam int ADC_BITS     = 8;
    localparam int ADC_CHANNELS = 32;
    localparam int FN_W         = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_READ = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    function automatic logic [FN_W-1:0] to_gray(input logic [FN_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [FN_W-1:0] from_gray(input logic [FN_W-1:0] g);
        logic [FN_W-1:0] b;
        b[FN_W-1] = g[FN_W-1];
        for (int i = FN_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/adc_gray_counter.sv
module adc_gray_counter
    import adc_pkg::*;
#(
    parameter int NBITS = ADC_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [NBITS-1:0] gray_o,
    output logic             at_top_o
);
    localparam logic [NBITS-1:0] TOP_BIN = '1;

    logic [NBITS-1:0] gray_q;
    logic [NBITS-1:0] next_bin;

    always_comb begin
        next_bin = NBITS'(from_gray(FN_W'(gray_q))) + NBITS'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gray_q <= '0;
        end else if (step) begin
            gray_q <= NBITS'(to_gray(FN_W'(next_bin)));
        end
    end

    assign gray_o   = gray_q;
    assign at_top_o = (gray_q == NBITS'(to_gray(FN_W'(TOP_BIN))));
endmodule

// File: rtl/adc_capture_bank.sv
module adc_capture_bank
    import adc_pkg::*;
#(
    parameter int NCH   = ADC_CHANNELS,
    parameter int NBITS = ADC_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      window,
    input  logic                      closing,
    input  logic [NBITS-1:0]          gray_i,
    input  logic [NCH-1:0]            cmp_i,
    output logic [NCH-1:0][NBITS-1:0] codes_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic             hit_q;
        logic [NBITS-1:0] code_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hit_q  <= 1'b0;
                code_q <= '0;
            end else if (clear) begin
                hit_q  <= 1'b0;
            end else if (window && !hit_q && (cmp_i[c] || closing)) begin
                hit_q  <= 1'b1;
                code_q <= gray_i;
            end
        end

        assign codes_o[c] = code_q;
    end
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_pkg::*;
#(
    parameter int NCH = ADC_CHANNELS,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           at_top_i,
    output phase_t         phase_o,
    output logic           begin_o,
    output logic [CHW-1:0] idx_o
);
    localparam logic [CHW-1:0] LAST_IDX = CHW'(NCH - 1);

    phase_t         phase_q;
    logic [CHW-1:0] idx_q;

    assign begin_o = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start_i) phase_q <= PH_RAMP;
                PH_RAMP: if (at_top_i) begin
                    phase_q <= PH_READ;
                    idx_q   <= '0;
                end
                PH_READ: begin
                    if (idx_q == LAST_IDX) begin
                        phase_q <= PH_DONE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + CHW'(1);
                    end
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
endmodule

// File: rtl/ramp_adc_backend.sv
module ramp_adc_backend
    import adc_pkg::*;
#(
    parameter int NCH   = ADC_CHANNELS,
    parameter int NBITS = ADC_BITS,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NCH-1:0]   cmp_i,
    output logic             ramp_en_o,
    output logic             rd_valid_o,
    output logic [CHW-1:0]   rd_chan_o,
    output logic [NBITS-1:0] rd_code_o,
    output logic             done_o
);
    phase_t                   phase;
    logic                     begin_conv;
    logic                     at_top;
    logic [CHW-1:0]           idx;
    logic [NBITS-1:0]         gray;
    logic [NCH-1:0][NBITS-1:0] codes;
    logic                     in_ramp;
    logic                     in_read;

    assign in_ramp = (phase == PH_RAMP);
    assign in_read = (phase == PH_READ);

    adc_sequencer #(.NCH(NCH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .at_top_i (at_top),
        .phase_o  (phase),
        .begin_o  (begin_conv),
        .idx_o    (idx)
    );

    adc_gray_counter #(.NBITS(NBITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (begin_conv),
        .step     (in_ramp),
        .gray_o   (gray),
        .at_top_o (at_top)
    );

    adc_capture_bank #(.NCH(NCH), .NBITS(NBITS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clear   (begin_conv),
        .window  (in_ramp),
        .closing (at_top),
        .gray_i  (gray),
        .cmp_i   (cmp_i),
        .codes_o (codes)
    );

    assign ramp_en_o  = in_ramp;
    assign rd_valid_o = in_read;
    assign rd_chan_o  = in_read ? idx : '0;
    assign rd_code_o  = in_read ? NBITS'(from_gray(FN_W'(codes[idx]))) : '0;
    assign done_o     = (phase == PH_DONE);
endmodule

// File: rtl/ramp_adc_backend_chk.sv
module ramp_adc_backend_chk
    import adc_pkg::*;
#(
    parameter int NCH   = ADC_CHANNELS,
    parameter int NBITS = ADC_BITS,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             ramp_en_o,
    input logic             rd_valid_o,
    input logic [CHW-1:0]   rd_chan_o,
    input logic             done_o
);
    localparam int RAMP_LEN = 1 << NBITS;

    logic [NBITS:0] ramp_cnt;
    always_ff @(posedge clk) begin
        if (rst || !ramp_en_o) ramp_cnt <= '0;
        else                   ramp_cnt <= ramp_cnt + 1'b1;
    end

    // R2
    ramp_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ramp_en_o) |-> ramp_cnt == (NBITS+1)'(RAMP_LEN));

    // R2
    ramp_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ramp_en_o |-> ramp_cnt < (NBITS+1)'(RAMP_LEN));

    // R6
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ramp_en_o) |-> rd_valid_o && rd_chan_o == '0);

    // R6
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o && $past(rd_valid_o) |-> rd_chan_o == $past(rd_chan_o) + CHW'(1));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(rd_valid_o) && $past(rd_chan_o) == CHW'(NCH - 1));

    // R7
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ramp_en_o, rd_valid_o, done_o}));

    // R8
    ramp_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_en_o) |-> $past(start_i) && !$past(rd_valid_o) && !$past(done_o));
endmodule

bind ramp_adc_backend ramp_adc_backend_chk #(.NCH(NCH), .NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ramp_en_o  (ramp_en_o),
    .rd_valid_o (rd_valid_o),
    .rd_chan_o  (rd_chan_o),
    .done_o     (done_o)
);

// File: tb/ramp_adc_backend_tb.sv
module ramp_adc_backend_tb;
    localparam int NCH   = 32;
    localparam int NBITS = 8;
    localparam int CHW   = 5;
    localparam int RLEN  = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [NCH-1:0]   cmp_i = '0;
    logic             ramp_en_o, rd_valid_o, done_o;
    logic [CHW-1:0]   rd_chan_o;
    logic [NBITS-1:0] rd_code_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    int thr    [NCH];
    bit glitch [NCH];

    always #2.5 clk = ~clk;

    ramp_adc_backend u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
        .ramp_en_o(ramp_en_o), .rd_valid_o(rd_valid_o), .rd_chan_o(rd_chan_o),
        .rd_code_o(rd_code_o), .done_o(done_o)
    );

    function automatic int expect_code(int t);
        return (t > RLEN - 1) ? RLEN - 1 : t;
    endfunction

    function automatic bit cmp_level(int c, int k);
        if (k < thr[c]) return 1'b0;
        if (glitch[c] && k > thr[c] && k < thr[c] + 5) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int spur_k, input int spur_ch);
        int ramp_seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < RLEN; k++) begin
            for (int c = 0; c < NCH; c++) cmp_i[c] = cmp_level(c, k);
            start_i = (k == spur_k);
            if (ramp_en_o) ramp_seen++;
            @(negedge clk);
        end
        start_i = 1'b0;
        cmp_i = '0;
        check(ramp_en_o == 1'b0 && ramp_seen == RLEN, "R2 ramp window length", ramp_seen, RLEN);
        for (int c = 0; c < NCH; c++) begin
            start_i = (c == spur_ch);
            check(rd_valid_o == 1'b1 && int'(rd_chan_o) == c, "R6 readout order", int'(rd_chan_o), c);
            if (thr[c] > RLEN - 1)
                check(int'(rd_code_o) == expect_code(thr[c]), "R5 overflow code", int'(rd_code_o), 255);
            else if (glitch[c])
                check(int'(rd_code_o) == expect_code(thr[c]), "R4 first crossing kept", int'(rd_code_o), thr[c]);
            else
                check(int'(rd_code_o) == expect_code(thr[c]), "R3 latched code", int'(rd_code_o), thr[c]);
            @(negedge clk);
        end
        start_i = (spur_ch == NCH);
        check(done_o == 1'b1 && rd_valid_o == 1'b0, "R7 done pulse", int'(done_o), 1);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0 && ramp_en_o == 1'b0 && rd_valid_o == 1'b0, "R7 idle after done",
              int'({ramp_en_o, rd_valid_o, done_o}), 0);
        @(negedge clk);
        check(ramp_en_o == 1'b0, "R8 no ramp from ignored start", int'(ramp_en_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!ramp_en_o && !rd_valid_o && !done_o && rd_chan_o == '0 && rd_code_o == '0,
              "R1 reset state", int'({ramp_en_o, rd_valid_o, done_o}), 0);

        // directed corners: count 0, 1, 254, 255, never, glitch
        for (int c = 0; c < NCH; c++) begin
            thr[c] = (c * 8 + 3) % 250;
            glitch[c] = 1'b0;
        end
        thr[0] = 0; thr[1] = 255; thr[2] = 300; thr[3] = 254;
        thr[4] = 1; thr[5] = 128; glitch[5] = 1'b1; thr[31] = 400;
        // R8: start during ramp
        run_conv(100, -1);

        // random scenarios, with start during readout and during done
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < NCH; c++) begin
                thr[c] = int'($urandom_range(0, 280));
                glitch[c] = ($urandom_range(0, 3) == 0);
            end
            run_conv((r % 2 == 0) ? int'($urandom_range(0, RLEN - 1)) : -1,
                     (r % 3 == 0) ? NCH : int'($urandom_range(0, NCH - 1)));
        end

        // all channels overflow
        for (int c = 0; c < NCH; c++) begin
            thr[c] = 1000;
            glitch[c] = 1'b0;
        end
        run_conv(-1, -1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule